// File: doc/BRIEF.md
# Parallel Flash Bus Front End

This block is the host side of a parallel NOR-style flash device. On every system clock it samples the active-low chip-enable, output-enable, write-enable and reset pins and decides which bus operation is in progress: read, write, standby, output disable or reset. It builds a byte-resolution array address. In word configuration the address comes from the address pins alone. In byte configuration the top data pin also serves as the least-significant address bit. Real tri-state pins are replaced by a data-out bus and a per-lane output-enable vector.

Each completed write cycle ends on the first sampled cycle in which write enable is high again. At that point the address and data are captured into a command register, which is not mapped into the array, and offered to a downstream command state machine for one cycle. While the write-protect pin is low, a write aimed at the boot sector at the array boundary is refused. The refused write changes nothing in storage and raises a one-cycle rejection flag. A small internal word array stands in for the flash cells so that reads can be observed.

Top module: `flash_bus_front`

## Requirements
- R1: With chip enable low, output enable low, write enable high and the reset pin high, the registered operation code is READ (3) and the stored word or byte is driven on the active lanes one clock later.
- R2: With chip enable low, write enable low and output enable high, the registered operation code is WRITE (4), and no lane is enabled.
- R3: With chip enable high and the reset pin high, the operation code is STANDBY (1) and every lane enable is 0, whatever output enable and write enable do.
- R4: With chip enable low and output enable and write enable both high or both low, the operation code is OUTDIS (2), no lane is enabled and no write is captured.
- R5: With the reset pin low, the operation code is RESET (0), all lane enables are 0, and a write cycle that is open at that moment is dropped without a command.
- R6: In word configuration (word_mode high) the command address is the 21-bit pin address followed by a 0 bit, and a read returns the full 16-bit word with enables 16'hFFFF.
- R7: In byte configuration (word_mode low) data pin 15 is the byte-select address bit (0 selects bits 7:0 of the word, 1 selects bits 15:8). Reads drive the selected byte on lanes 7:0 with enables 16'h00FF and lanes 15:8 at 0. Writes change only the selected byte.
- R8: When write enable is sampled high in the cycle after a WRITE cycle, the command register captures the address and the lane-masked data (byte mode: upper 8 bits 0) and sets cmd_byte for byte mode. cmd_valid is high for exactly the following cycle.
- R9: The sector number is address bits 20:12 in both configurations. With wprot_n low, the boot sector (sector 0 when BOOT_TOP is 0, sector 511 when it is 1) is protected. All other sectors, and the boot sector while wprot_n is high, accept writes.
- R10: A write to a protected sector leaves the array unchanged and issues no cmd_valid. Instead wr_reject is high for exactly one cycle, at the time cmd_valid would have been.
- R11: While the synchronous rst input is high, the operation code is RESET, all lanes are disabled, cmd_valid and wr_reject are 0, and the array is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hw_reset_n | input | 1 | Device reset pin, active low |
| word_mode | input | 1 | 1 = word configuration, 0 = byte configuration |
| wprot_n | input | 1 | Boot-sector write protect, active low |
| addr | input | 21 | Word address pins |
| dq_in | input | 16 | Data pins as seen inbound; bit 15 is the byte-select address bit in byte mode |
| dq_out | output | 16 | Read data towards the pins |
| dq_oe | output | 16 | Per-lane output enable |
| op | output | 3 | Registered operation code (0 RESET, 1 STANDBY, 2 OUTDIS, 3 READ, 4 WRITE) |
| cmd_valid | output | 1 | One-cycle strobe: command register holds a new write |
| cmd_addr | output | 22 | Captured byte-resolution address |
| cmd_data | output | 16 | Captured write data |
| cmd_byte | output | 1 | Captured write was a byte-mode write |
| wr_reject | output | 1 | One-cycle flag: write refused by boot-sector protection |

## Verification
The operation code, lane enables and read data are all registered, so each appears after the first rising edge following the pin change. The command strobe and rejection flag appear after the edge that samples write enable back high, and they clear after the next edge. The bench changes pins just after a falling edge and reads outputs at the next falling edge, which lies half a period after the edge that updated them. After every strobe it takes one more step to confirm that the strobe lasts a single cycle.

// File: rtl/flash_front_pkg.sv
package flash_front_pkg;

    localparam int DQ_W   = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_RESET   = 3'd0,
        OP_STANDBY = 3'd1,
        OP_OUTDIS  = 3'd2,
        OP_READ    = 3'd3,
        OP_WRITE   = 3'd4
    } bus_op_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic rst_n;
    } bus_ctrl_t;

    // Reset pin dominates, then chip enable, then the OE/WE pair.
    function automatic bus_op_e decode_op(input bus_ctrl_t c);
        if (!c.rst_n)              return OP_RESET;
        if (c.ce_n)                return OP_STANDBY;
        if (!c.oe_n && c.we_n)     return OP_READ;
        if (c.oe_n && !c.we_n)     return OP_WRITE;
        return OP_OUTDIS;
    endfunction

    function automatic logic [DQ_W-1:0] lane_enables(input logic word_mode);
        return word_mode ? {DQ_W{1'b1}} : {{(DQ_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
    endfunction

endpackage

// File: rtl/flash_bus_decode.sv
module flash_bus_decode
    import flash_front_pkg::*;
#(
    parameter int WADDR_W = 21
) (
    input  bus_ctrl_t              ctrl,
    input  logic                   word_mode,
    input  logic [WADDR_W-1:0]     addr,
    input  logic [DQ_W-1:0]        dq_in,
    output bus_op_e                op,
    output logic [WADDR_W:0]       baddr,
    output logic [DQ_W-1:0]        wdata
);

    assign op    = decode_op(ctrl);
    // Byte mode: top data pin supplies the sub-word address bit.
    assign baddr = {addr, (word_mode ? 1'b0 : dq_in[DQ_W-1])};
    assign wdata = dq_in & lane_enables(word_mode);

endmodule

// File: rtl/flash_cmd_latch.sv
module flash_cmd_latch
    import flash_front_pkg::*;
#(
    parameter int BADDR_W  = 22,
    parameter int SECT_W   = 9,
    parameter bit BOOT_TOP = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_op_e             op,
    input  logic                we_n,
    input  logic                word_mode,
    input  logic                wprot_n,
    input  logic [BADDR_W-1:0]  baddr,
    input  logic [DQ_W-1:0]     wdata,
    output logic                mem_we,
    output logic                cmd_valid,
    output logic [BADDR_W-1:0]  cmd_addr,
    output logic [DQ_W-1:0]     cmd_data,
    output logic                cmd_byte,
    output logic                wr_reject
);

    localparam logic [SECT_W-1:0] BOOT_SECT = {SECT_W{BOOT_TOP}};

    logic wr_seen;
    logic we_rise;
    logic is_prot;

    assign we_rise = wr_seen && we_n && (op != OP_RESET);
    assign is_prot = !wprot_n && (baddr[BADDR_W-1 -: SECT_W] == BOOT_SECT);
    assign mem_we  = we_rise && !is_prot;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_seen   <= 1'b0;
            cmd_valid <= 1'b0;
            wr_reject <= 1'b0;
            cmd_addr  <= '0;
            cmd_data  <= '0;
            cmd_byte  <= 1'b0;
        end else begin
            wr_seen   <= (op == OP_WRITE);
            cmd_valid <= we_rise && !is_prot;
            wr_reject <= we_rise && is_prot;
            if (we_rise && !is_prot) begin
                cmd_addr <= baddr;
                cmd_data <= wdata;
                cmd_byte <= !word_mode;
            end
        end
    end

    AST_CMD_ONE_SHOT:  assert property (@(posedge clk) disable iff (rst) cmd_valid |=> !cmd_valid); // R8
    AST_REJ_ONE_SHOT:  assert property (@(posedge clk) disable iff (rst) wr_reject |=> !wr_reject); // R10
    AST_REJ_NEEDS_WP:  assert property (@(posedge clk) disable iff (rst) wr_reject |-> !$past(wprot_n)); // R9

endmodule

// File: rtl/flash_array_model.sv
module flash_array_model
    import flash_front_pkg::*;
#(
    parameter int BADDR_W = 22,
    parameter int SECT_W  = 9,
    parameter int MEM_AW  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_op_e             op,
    input  logic                word_mode,
    input  logic [BADDR_W-1:0]  baddr,
    input  logic                mem_we,
    input  logic [DQ_W-1:0]     wdata,
    output logic [DQ_W-1:0]     dq_out,
    output logic [DQ_W-1:0]     dq_oe
);

    localparam int DEPTH    = 1 << MEM_AW;
    localparam int SECT_BIT = BADDR_W - SECT_W;

    logic [DQ_W-1:0]   mem [DEPTH];
    logic [MEM_AW-1:0] idx;
    logic [DQ_W-1:0]   word_q;

    // Sector LSB plus low word-address bits pick the stand-in cell.
    assign idx    = {baddr[SECT_BIT], baddr[MEM_AW-1:1]};
    assign word_q = mem[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            dq_out <= '0;
            dq_oe  <= '0;
        end else begin
            if (mem_we) begin
                if (word_mode)
                    mem[idx] <= wdata;
                else if (baddr[0])
                    mem[idx][DQ_W-1:BYTE_W] <= wdata[BYTE_W-1:0];
                else
                    mem[idx][BYTE_W-1:0] <= wdata[BYTE_W-1:0];
            end
            if (op == OP_READ) begin
                dq_oe  <= lane_enables(word_mode);
                dq_out <= word_mode ? word_q
                        : {{(DQ_W-BYTE_W){1'b0}},
                           (baddr[0] ? word_q[DQ_W-1:BYTE_W] : word_q[BYTE_W-1:0])};
            end else begin
                dq_oe  <= '0;
                dq_out <= '0;
            end
        end
    end

    AST_BYTE_UPPER_QUIET: assert property (@(posedge clk) disable iff (rst)
        !word_mode |=> (dq_oe[DQ_W-1:BYTE_W] == '0 && dq_out[DQ_W-1:BYTE_W] == '0)); // R7
    AST_DRIVE_ONLY_READ:  assert property (@(posedge clk) disable iff (rst)
        (op != OP_READ) |=> (dq_oe == '0)); // R4

endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
    import flash_front_pkg::*;
#(
    parameter int WADDR_W  = 21,
    parameter int SECT_W   = 9,
    parameter int MEM_AW   = 4,
    parameter bit BOOT_TOP = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ce_n,
    input  logic               oe_n,
    input  logic               we_n,
    input  logic               hw_reset_n,
    input  logic               word_mode,
    input  logic               wprot_n,
    input  logic [WADDR_W-1:0] addr,
    input  logic [15:0]        dq_in,
    output logic [15:0]        dq_out,
    output logic [15:0]        dq_oe,
    output logic [2:0]         op,
    output logic               cmd_valid,
    output logic [WADDR_W:0]   cmd_addr,
    output logic [15:0]        cmd_data,
    output logic               cmd_byte,
    output logic               wr_reject
);

    localparam int BADDR_W = WADDR_W + 1;

    bus_ctrl_t           ctrl;
    bus_op_e             op_now;
    bus_op_e             op_q;
    logic [BADDR_W-1:0]  baddr;
    logic [DQ_W-1:0]     wdata;
    logic                mem_we;

    assign ctrl = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, rst_n: hw_reset_n};

    flash_bus_decode #(.WADDR_W(WADDR_W)) u_decode (
        .ctrl(ctrl), .word_mode(word_mode), .addr(addr), .dq_in(dq_in),
        .op(op_now), .baddr(baddr), .wdata(wdata)
    );

    flash_cmd_latch #(.BADDR_W(BADDR_W), .SECT_W(SECT_W), .BOOT_TOP(BOOT_TOP)) u_cmd (
        .clk(clk), .rst(rst), .op(op_now), .we_n(we_n), .word_mode(word_mode),
        .wprot_n(wprot_n), .baddr(baddr), .wdata(wdata), .mem_we(mem_we),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_byte(cmd_byte), .wr_reject(wr_reject)
    );

    flash_array_model #(.BADDR_W(BADDR_W), .SECT_W(SECT_W), .MEM_AW(MEM_AW)) u_array (
        .clk(clk), .rst(rst), .op(op_now), .word_mode(word_mode), .baddr(baddr),
        .mem_we(mem_we), .wdata(wdata), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) op_q <= OP_RESET;
        else     op_q <= op_now;
    end

    assign op = op_q;

    AST_STANDBY_HIZ:  assert property (@(posedge clk) disable iff (rst)
        ce_n |=> (dq_oe == '0)); // R3
    AST_RESETPIN_HIZ: assert property (@(posedge clk) disable iff (rst)
        !hw_reset_n |=> (dq_oe == '0 && !cmd_valid && op == OP_RESET)); // R5
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (hw_reset_n && !ce_n && oe_n && !we_n) |=> (op == OP_WRITE && dq_oe == '0)); // R2

endmodule

// File: tb/flash_bus_front_bench.sv
`timescale 1ns/1ps
module flash_bus_front_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        ce_n, oe_n, we_n, hw_reset_n, word_mode, wprot_n;
    logic [20:0] addr;
    logic [15:0] dq_in;
    logic [15:0] dq_out, dq_oe;
    logic [2:0]  op;
    logic        cmd_valid, cmd_byte, wr_reject;
    logic [21:0] cmd_addr;
    logic [15:0] cmd_data;

    int  nchk = 0;
    int  nfail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    flash_bus_front u_flash_bus_front (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .hw_reset_n(hw_reset_n), .word_mode(word_mode), .wprot_n(wprot_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .op(op),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_byte(cmd_byte), .wr_reject(wr_reject)
    );

    typedef struct packed {
        logic        ce_n, oe_n, we_n, rst_n, wm;
        logic [2:0]  exp_op;
        logic [15:0] exp_oe;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 3'd1, 16'h0000, 4'd3},  // R3 idle
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 16'h0000, 4'd3},  // R3 OE/WE ignored
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd3, 16'hFFFF, 4'd1},  // R1 word read
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd3, 16'h00FF, 4'd7},  // R7 byte read
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 3'd2, 16'h0000, 4'd4},  // R4 both high
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 16'h0000, 4'd4},  // R4 both low
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd4, 16'h0000, 4'd2},  // R2 write
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 16'h0000, 4'd5},  // R5 over read
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 16'h0000, 4'd5},  // R5 over standby
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 16'h0000, 4'd5}   // R5 over write
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; hw_reset_n = 1'b1;
    endtask

    task automatic do_write(input logic [20:0] a, input logic [15:0] d, input logic wm,
                            input bit ok, input string tag);
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a; dq_in = d; word_mode = wm;
        step();
        we_n = 1'b1;
        step();
        chk({tag, " R8 cmd_valid"}, cmd_valid, ok);
        chk({tag, " R10 wr_reject"}, wr_reject, !ok);
        if (ok) begin
            chk({tag, " R6/R7 cmd_addr"}, cmd_addr, {a, (wm ? 1'b0 : d[15])});
            chk({tag, " R8 cmd_data"}, cmd_data, wm ? d : {8'h00, d[7:0]});
            chk({tag, " R8 cmd_byte"}, cmd_byte, !wm);
        end
        idle();
        step();
        chk({tag, " R8 R10 one-cycle strobe"}, {cmd_valid, wr_reject}, 2'b00);
    endtask

    task automatic do_read(input logic [20:0] a, input logic wm, input logic lsb,
                           output logic [15:0] d, output logic [15:0] en);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a; word_mode = wm;
        dq_in = {lsb, 15'h0};
        step();
        d = dq_out; en = dq_oe;
        idle();
        step();
    endtask

    initial begin
        #400000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd, en;
        rst = 1'b1; idle(); word_mode = 1'b1; wprot_n = 1'b1; addr = '0; dq_in = '0;
        @(negedge clk);
        step();
        // R11 reset state
        chk("R11 op in reset", op, 3'd0);
        chk("R11 dq_oe in reset", dq_oe, 16'h0000);
        chk("R11 strobes in reset", {cmd_valid, wr_reject}, 2'b00);
        rst = 1'b0;
        step();
        chk("R3 standby after reset", op, 3'd1);

        for (int i = 0; i < NVEC; i++) begin
            ce_n = VECS[i].ce_n; oe_n = VECS[i].oe_n; we_n = VECS[i].we_n;
            hw_reset_n = VECS[i].rst_n; word_mode = VECS[i].wm;
            step();
            chk($sformatf("R%0d vec %0d op", VECS[i].req, i), op, VECS[i].exp_op);
            chk($sformatf("R%0d vec %0d dq_oe", VECS[i].req, i), dq_oe, VECS[i].exp_oe);
        end
        idle(); word_mode = 1'b1;
        step();

        // R11 array cleared
        do_read(21'h001005, 1'b1, 1'b0, rd, en);
        chk("R11 cleared cell", rd, 16'h0000);

        // R6 word write and read
        do_write(21'h001005, 16'hBEEF, 1'b1, 1'b1, "R6 word write");
        do_read(21'h001005, 1'b1, 1'b0, rd, en);
        chk("R1 R6 word read data", rd, 16'hBEEF);
        chk("R6 word read lanes", en, 16'hFFFF);

        // R7 byte reads
        do_read(21'h001005, 1'b0, 1'b1, rd, en);
        chk("R7 byte read high", rd, 16'h00BE);
        chk("R7 byte lanes", en, 16'h00FF);
        do_read(21'h001005, 1'b0, 1'b0, rd, en);
        chk("R7 byte read low", rd, 16'h00EF);

        // R7 byte writes touch one byte only
        do_write(21'h001005, 16'h7712, 1'b0, 1'b1, "R7 byte write low");
        do_read(21'h001005, 1'b1, 1'b0, rd, en);
        chk("R7 low byte merged", rd, 16'hBE12);
        do_write(21'h001005, 16'h8034, 1'b0, 1'b1, "R7 byte write high");
        do_read(21'h001005, 1'b1, 1'b0, rd, en);
        chk("R7 high byte merged", rd, 16'h3412);

        // R9 boot sector writable while protect pin high
        do_write(21'h000005, 16'h1234, 1'b1, 1'b1, "R9 boot unlocked");
        do_read(21'h000005, 1'b1, 1'b0, rd, en);
        chk("R9 boot write landed", rd, 16'h1234);

        // R10 protected write refused
        wprot_n = 1'b0;
        do_write(21'h000005, 16'hFFFF, 1'b1, 1'b0, "R10 boot locked");
        do_read(21'h000005, 1'b1, 1'b0, rd, en);
        chk("R10 boot cell unchanged", rd, 16'h1234);
        do_write(21'h000FFF, 16'h0F0F, 1'b1, 1'b0, "R9 boot sector top word");

        // R9 other sectors still writable
        do_write(21'h001006, 16'h5555, 1'b1, 1'b1, "R9 sector 1");
        do_read(21'h001006, 1'b1, 1'b0, rd, en);
        chk("R9 sector 1 data", rd, 16'h5555);
        do_write(21'h1FF005, 16'hAAAA, 1'b1, 1'b1, "R9 last sector");
        do_read(21'h1FF005, 1'b1, 1'b0, rd, en);
        chk("R9 last sector data", rd, 16'hAAAA);
        wprot_n = 1'b1;

        // R4 OE and WE both low is not a write
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = 21'h001006; dq_in = 16'h0000; word_mode = 1'b1;
        step();
        we_n = 1'b1; oe_n = 1'b1;
        step();
        chk("R4 no command from OE+WE low", cmd_valid, 1'b0);
        idle(); step();
        do_read(21'h001006, 1'b1, 1'b0, rd, en);
        chk("R4 cell untouched", rd, 16'h5555);

        // R5 reset pin drops an open write
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = 21'h001006; dq_in = 16'h9999;
        step();
        we_n = 1'b1; hw_reset_n = 1'b0;
        step();
        chk("R5 no command under reset pin", cmd_valid, 1'b0);
        chk("R5 op reset", op, 3'd0);
        idle(); step();
        do_read(21'h001006, 1'b1, 1'b0, rd, en);
        chk("R5 cell untouched", rd, 16'h5555);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule